// File: doc/BRIEF.md
# Dual-line CCD clock sequencer

This block produces every digital drive pulse that a six-line colour linear CCD needs. There are three colours, and each colour has a main line and a sub line. The two lines are read out interleaved on a single analog output per colour. All timing comes from one master clock through a programmable tick divider, so every interval in the block is a whole number of ticks. A start-of-line request opens a transfer-gate window and then runs a full readout:

1. The slow register clock is held high for a setup interval.
2. The transfer gate pulses high.
3. After a short hold, the slow and fast clock pairs run for the configured number of pixel periods.

Each pixel period lasts four ticks. The slow register clock, with its latch copy, completes one cycle per pixel. The fast output clock completes two cycles per pixel: the first sample carries the main line and the second carries the sub line. A one-master-cycle reset pulse opens every sample.

Each colour has its own shutter pulse. The shutter is high (charge drained) outside readout and falls at a programmed pixel index. A release index that lands inside the effective-pixel window is moved to the first effective pixel. The shutter therefore never changes level while effective pixels stream out. A request that arrives while a line is in progress is remembered, and the next setup begins the moment the current line ends. A line-valid marker and a sub-sample flag let a downstream pixel counter frame the data.

Top module: `ccd_line_sequencer`

## Requirements
- R1: The tick divider produces one tick every cfg_div+1 master cycles, where cfg_div is at least 1. With T = cfg_div+1, line_valid stays high for exactly cfg_line_pix*4*T master cycles per line.
- R2: A line starts with reg_clk1 high for at least SETUP_TICKS*T cycles before xfer_gate rises. xfer_gate is then high for exactly ROG_TICKS*T cycles. line_valid rises exactly HOLD_TICKS*T cycles after xfer_gate falls. reg_clk1 is high whenever xfer_gate is high and in the cycle where it falls.
- R3: During readout, reg_clk1 and lat_clk1 are high for the first two ticks of each pixel and low for the last two, so reg_clk1 falls exactly cfg_line_pix times per line. reg_clk2 and lat_clk2 are always the complement of reg_clk1. reg_clk1 falls only while line_valid is high, and xfer_gate is never high together with line_valid.
- R4: out_clk_a is high during the first tick of each of the two samples in a pixel, giving 2*cfg_line_pix rising edges per line. out_clk_b is always its complement. sub_sample is high during the second sample of each pixel, for cfg_line_pix*2*T cycles per line.
- R5: sample_reset is high for exactly one master cycle at the start of every sample, 2*cfg_line_pix pulses per line, and is low outside readout.
- R6: Each shutter bit is high outside readout. During readout it is high while the pixel index is below the effective release point, so it falls exactly release*4*T cycles after line_valid rises. Colour c uses cfg_release bits [c*PIX_W +: PIX_W].
- R7: A release value in [EFF_FIRST, EFF_FIRST+EFF_COUNT) acts as EFF_FIRST. A release value of cfg_line_pix or more gives no fall during the line. No shutter bit rises while line_valid is high, and none changes level inside the effective window.
- R8: A start_req during a line is held. The next xfer_gate rises exactly SETUP_TICKS*T cycles after line_valid falls. Several requests during one line produce only one extra line.
- R9: After reset, xfer_gate=0, reg_clk1=1, reg_clk2=0, lat_clk1=1, lat_clk2=0, out_clk_a=0, out_clk_b=1, sample_reset=0, line_valid=0, sub_sample=0, and all shutter bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Start-of-line request pulse |
| cfg_div | input | DIV_W | Master cycles per tick minus one (at least 1) |
| cfg_line_pix | input | PIX_W | Pixel periods per line |
| cfg_release | input | NCOL*PIX_W | Shutter release pixel index per colour |
| xfer_gate | output | 1 | Transfer-gate pulse |
| reg_clk1 | output | 1 | Slow register clock, phase 1 |
| reg_clk2 | output | 1 | Slow register clock, phase 2 |
| lat_clk1 | output | 1 | Last-stage clock, phase 1 (drives both latch phase-1 pins) |
| lat_clk2 | output | 1 | Last-stage clock, phase 2 |
| out_clk_a | output | 1 | Fast output clock, phase A |
| out_clk_b | output | 1 | Fast output clock, phase B |
| sample_reset | output | 1 | Output-node reset pulse, one per sample |
| shutter | output | NCOL | Per-colour shutter pulses |
| line_valid | output | 1 | High during the readout of a line |
| sub_sample | output | 1 | High while the current sample is from the sub line |

## Verification
The hardest case to reach is a request that arrives while a line is still streaming. The held request must start the next setup at exactly the line's last tick, and a second request in the same line must not stack into a third line. The bench pulses start_req twice after line_valid rises. It then times the gap from line_valid falling to the next transfer gate, and confirms that the sequencer goes idle after one extra line. The shutter clamp is reached by sweeping one colour's release index across every value below, inside and beyond the effective window, for three divider settings. Each shutter fall is timed against line_valid.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_GATE  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_READ  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/ccd_tick_div.sv
module ccd_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             tick,
  output logic             tick_first
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick       = (cnt_q >= cfg_div);
    tick_first = (cnt_q == '0);
    cnt_d      = tick ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ccd_line_fsm.sv
module ccd_line_fsm
  import ccd_seq_pkg::*;
#(
  parameter int PIX_W       = 13,
  parameter int SETUP_TICKS = 30,
  parameter int ROG_TICKS   = 30,
  parameter int HOLD_TICKS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_req,
  input  logic [PIX_W-1:0] cfg_line_pix,
  output seq_state_t       state_o,
  output logic [1:0]       phase_o,
  output logic [PIX_W-1:0] pix_o
);
  localparam int MAX_A = (SETUP_TICKS > ROG_TICKS) ? SETUP_TICKS : ROG_TICKS;
  localparam int MAX_T = (MAX_A > HOLD_TICKS) ? MAX_A : HOLD_TICKS;
  localparam int TC_W  = (MAX_T > 1) ? $clog2(MAX_T) : 1;

  seq_state_t       st_q, st_d;
  logic [TC_W-1:0]  tc_q, tc_d;
  logic [1:0]       ph_q, ph_d;
  logic [PIX_W-1:0] px_q, px_d;
  logic             pend_q, pend_d;
  logic             want;

  always_comb begin
    want   = pend_q | start_req;
    pend_d = want;
    st_d   = st_q;
    tc_d   = tc_q;
    ph_d   = ph_q;
    px_d   = px_q;
    // the tick-qualified part: only takes effect when tick is high
    case (st_q)
      ST_IDLE: begin
        if (want && tick) begin
          st_d   = ST_SETUP;
          tc_d   = '0;
          pend_d = 1'b0;
        end
      end
      ST_SETUP: begin
        if (tc_q == TC_W'(SETUP_TICKS - 1)) begin
          st_d = ST_GATE;
          tc_d = '0;
        end else begin
          tc_d = tc_q + TC_W'(1);
        end
      end
      ST_GATE: begin
        if (tc_q == TC_W'(ROG_TICKS - 1)) begin
          st_d = ST_HOLD;
          tc_d = '0;
        end else begin
          tc_d = tc_q + TC_W'(1);
        end
      end
      ST_HOLD: begin
        if (tc_q == TC_W'(HOLD_TICKS - 1)) begin
          st_d = ST_READ;
          tc_d = '0;
          ph_d = 2'd0;
          px_d = '0;
        end else begin
          tc_d = tc_q + TC_W'(1);
        end
      end
      ST_READ: begin
        ph_d = ph_q + 2'd1;
        if (ph_q == 2'd3) begin
          if (px_q == cfg_line_pix - PIX_W'(1)) begin
            if (want) begin
              st_d = ST_SETUP;
              tc_d = '0;
              if (tick) pend_d = 1'b0;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            px_d = px_q + PIX_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tc_q   <= '0;
      ph_q   <= 2'd0;
      px_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (tick) begin
        st_q <= st_d;
        tc_q <= tc_d;
        ph_q <= ph_d;
        px_q <= px_d;
      end
    end
  end

  assign state_o = st_q;
  assign phase_o = ph_q;
  assign pix_o   = px_q;
endmodule

// File: rtl/ccd_shutter_gate.sv
module ccd_shutter_gate #(
  parameter int NCOL      = 3,
  parameter int PIX_W     = 13,
  parameter int EFF_FIRST = 44,
  parameter int EFF_COUNT = 5350
) (
  input  logic                  reading,
  input  logic [PIX_W-1:0]      pix,
  input  logic [NCOL*PIX_W-1:0] cfg_release,
  output logic [NCOL-1:0]       shut_d
);
  localparam logic [PIX_W:0] EF_X = (PIX_W+1)'(EFF_FIRST);
  localparam logic [PIX_W:0] EE_X = (PIX_W+1)'(EFF_FIRST + EFF_COUNT);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [PIX_W:0] rel_raw, rel_eff;
    always_comb begin
      rel_raw = {1'b0, cfg_release[c*PIX_W +: PIX_W]};
      if (rel_raw >= EF_X && rel_raw < EE_X) rel_eff = EF_X;
      else                                   rel_eff = rel_raw;
      shut_d[c] = !reading || ({1'b0, pix} < rel_eff);
    end
  end
endmodule

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int PIX_W       = 13,
  parameter int NCOL        = 3,
  parameter int EFF_FIRST   = 44,
  parameter int EFF_COUNT   = 5350,
  parameter int SETUP_TICKS = 30,
  parameter int ROG_TICKS   = 30,
  parameter int HOLD_TICKS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_req,
  input  logic [DIV_W-1:0]      cfg_div,
  input  logic [PIX_W-1:0]      cfg_line_pix,
  input  logic [NCOL*PIX_W-1:0] cfg_release,
  output logic                  xfer_gate,
  output logic                  reg_clk1,
  output logic                  reg_clk2,
  output logic                  lat_clk1,
  output logic                  lat_clk2,
  output logic                  out_clk_a,
  output logic                  out_clk_b,
  output logic                  sample_reset,
  output logic [NCOL-1:0]       shutter,
  output logic                  line_valid,
  output logic                  sub_sample
);
  logic             tick, tick_first;
  seq_state_t       fsm_state;
  logic [1:0]       fsm_phase;
  logic [PIX_W-1:0] fsm_pix;
  logic             fsm_reading;
  logic [NCOL-1:0]  shut_d;
  logic gate_d, p1_d, p3_d, rs_d, lv_d, sub_d;

  ccd_tick_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
    .tick(tick), .tick_first(tick_first)
  );

  ccd_line_fsm #(
    .PIX_W(PIX_W), .SETUP_TICKS(SETUP_TICKS),
    .ROG_TICKS(ROG_TICKS), .HOLD_TICKS(HOLD_TICKS)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req),
    .cfg_line_pix(cfg_line_pix), .state_o(fsm_state),
    .phase_o(fsm_phase), .pix_o(fsm_pix)
  );

  assign fsm_reading = (fsm_state == ST_READ);

  ccd_shutter_gate #(
    .NCOL(NCOL), .PIX_W(PIX_W), .EFF_FIRST(EFF_FIRST), .EFF_COUNT(EFF_COUNT)
  ) shut_i (
    .reading(fsm_reading), .pix(fsm_pix),
    .cfg_release(cfg_release), .shut_d(shut_d)
  );

  always_comb begin
    gate_d = (fsm_state == ST_GATE);
    p1_d   = !fsm_reading || !fsm_phase[1];
    p3_d   = fsm_reading && !fsm_phase[0];
    rs_d   = fsm_reading && tick_first && !fsm_phase[0];
    lv_d   = fsm_reading;
    sub_d  = fsm_reading && fsm_phase[1];
  end

  // one flop per pin so no output is a copy of a shared net
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_gate    <= 1'b0;
      reg_clk1     <= 1'b1;
      reg_clk2     <= 1'b0;
      lat_clk1     <= 1'b1;
      lat_clk2     <= 1'b0;
      out_clk_a    <= 1'b0;
      out_clk_b    <= 1'b1;
      sample_reset <= 1'b0;
      shutter      <= '1;
      line_valid   <= 1'b0;
      sub_sample   <= 1'b0;
    end else begin
      xfer_gate    <= gate_d;
      reg_clk1     <= p1_d;
      reg_clk2     <= !p1_d;
      lat_clk1     <= p1_d;
      lat_clk2     <= !p1_d;
      out_clk_a    <= p3_d;
      out_clk_b    <= !p3_d;
      sample_reset <= rs_d;
      shutter      <= shut_d;
      line_valid   <= lv_d;
      sub_sample   <= sub_d;
    end
  end
endmodule

// File: rtl/ccd_line_sequencer_chk.sv
module ccd_line_sequencer_chk #(
  parameter int PIX_W     = 13,
  parameter int NCOL      = 3,
  parameter int EFF_FIRST = 44,
  parameter int EFF_COUNT = 5350
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_gate,
  input logic             reg_clk1,
  input logic             line_valid,
  input logic             sample_reset,
  input logic [NCOL-1:0]  shutter,
  input logic             reading,
  input logic [PIX_W-1:0] pix
);
  localparam logic [PIX_W:0] EF_X = (PIX_W+1)'(EFF_FIRST);
  localparam logic [PIX_W:0] EE_X = (PIX_W+1)'(EFF_FIRST + EFF_COUNT);

  logic in_win;
  assign in_win = reading && ({1'b0, pix} >= EF_X) && ({1'b0, pix} < EE_X);

  assert_gate_phi1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> reg_clk1);

  assert_gate_end_phi1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_gate) |-> reg_clk1);

  assert_gate_not_reading_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> !line_valid);

  assert_phi1_fall_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_clk1) |-> line_valid);

  assert_reset_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_reset |=> !sample_reset);

  assert_reset_in_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_reset |-> line_valid);

  assert_shutter_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_win) && $past(in_win, 2)) |-> $stable(shutter));
endmodule

bind ccd_line_sequencer ccd_line_sequencer_chk #(
  .PIX_W(PIX_W), .NCOL(NCOL), .EFF_FIRST(EFF_FIRST), .EFF_COUNT(EFF_COUNT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .xfer_gate(xfer_gate), .reg_clk1(reg_clk1),
  .line_valid(line_valid), .sample_reset(sample_reset), .shutter(shutter),
  .reading(fsm_reading), .pix(fsm_pix)
);

// File: tb/ccd_line_sequencer_tb.sv
`timescale 1ns/1ps
module ccd_line_sequencer_tb_top;
  localparam int DIV_W = 8, PIX_W = 13, NCOL = 3;
  localparam int EF = 4, EC = 6, SETUP = 3, ROG = 4, HOLD = 2, LINE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic [DIV_W-1:0] cfg_div = 8'd1;
  logic [PIX_W-1:0] cfg_line_pix = PIX_W'(LINE);
  logic [NCOL*PIX_W-1:0] cfg_release = '0;
  logic xfer_gate, reg_clk1, reg_clk2, lat_clk1, lat_clk2;
  logic out_clk_a, out_clk_b, sample_reset, line_valid, sub_sample;
  logic [NCOL-1:0] shutter;

  always #2 clk = ~clk;

  ccd_line_sequencer #(
    .DIV_W(DIV_W), .PIX_W(PIX_W), .NCOL(NCOL), .EFF_FIRST(EF), .EFF_COUNT(EC),
    .SETUP_TICKS(SETUP), .ROG_TICKS(ROG), .HOLD_TICKS(HOLD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_div(cfg_div),
    .cfg_line_pix(cfg_line_pix), .cfg_release(cfg_release),
    .xfer_gate(xfer_gate), .reg_clk1(reg_clk1), .reg_clk2(reg_clk2),
    .lat_clk1(lat_clk1), .lat_clk2(lat_clk2), .out_clk_a(out_clk_a),
    .out_clk_b(out_clk_b), .sample_reset(sample_reset), .shutter(shutter),
    .line_valid(line_valid), .sub_sample(sub_sample)
  );

  integer n_checks = 0, n_fail = 0, cyc = 0, lines_done = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input integer act, input integer exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // line monitor
  logic pg = 0, pp1 = 1, pp3 = 0, prs = 0, plv = 0;
  logic [NCOL-1:0] psh = '1;
  integer rog_rise_t = 0, rog_fall_t = 0, p1_rise_t = 0, lv_rise_t = 0, lv_fall_t = 0;
  integer rog_w = 0, setup_gap = 0, end_gap = 0, hold_gap = 0, lv_w = 0;
  integer n_p1f = 0, n_p3r = 0, n_rs = 0, n_rs_long = 0, n_sub = 0, n_comp = 0, n_shrise = 0;
  integer sh_fall [NCOL];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (xfer_gate && !pg) begin
        rog_rise_t = cyc; setup_gap = cyc - p1_rise_t; end_gap = cyc - lv_fall_t;
        n_p1f = 0; n_p3r = 0; n_rs = 0; n_rs_long = 0; n_sub = 0; n_comp = 0; n_shrise = 0;
        for (int c = 0; c < NCOL; c++) sh_fall[c] = -1;
      end
      if (!xfer_gate && pg) begin rog_w = cyc - rog_rise_t; rog_fall_t = cyc; end
      if (reg_clk1 && !pp1) p1_rise_t = cyc;
      if (line_valid && !plv) begin lv_rise_t = cyc; hold_gap = cyc - rog_fall_t; end
      if (reg_clk2 !== !reg_clk1 || lat_clk1 !== reg_clk1 || lat_clk2 !== !reg_clk1 ||
          out_clk_b !== !out_clk_a) n_comp++;
      if (line_valid) begin
        if (!reg_clk1 && pp1) n_p1f++;
        if (out_clk_a && !pp3) n_p3r++;
        if (sample_reset) n_rs++;
        if (sample_reset && prs) n_rs_long++;
        if (sub_sample) n_sub++;
        for (int c = 0; c < NCOL; c++) begin
          if (!shutter[c] && psh[c] && sh_fall[c] < 0) sh_fall[c] = cyc - lv_rise_t;
          if (shutter[c] && !psh[c]) n_shrise++;
        end
      end
      if (!line_valid && plv) begin lv_w = cyc - lv_rise_t; lv_fall_t = cyc; lines_done++; end
    end
    pg = xfer_gate; pp1 = reg_clk1; pp3 = out_clk_a; prs = sample_reset;
    plv = line_valid; psh = shutter;
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic integer exp_fall(input integer rel, input integer t);
    integer r;
    r = (rel >= EF && rel < EF + EC) ? EF : rel;
    return (r >= LINE) ? -1 : r * 4 * t;
  endfunction

  task automatic pulse_req();
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  task automatic check_line(input integer t, input integer rel0);
    integer rels [NCOL];
    rels[0] = rel0; rels[1] = 6; rels[2] = 20;
    chk(rog_w == ROG * t, "R2 gate width", rog_w, ROG * t);
    chk(setup_gap >= SETUP * t, "R2 setup before gate", setup_gap, SETUP * t);
    chk(hold_gap == HOLD * t, "R2 hold after gate", hold_gap, HOLD * t);
    chk(lv_w == LINE * 4 * t, "R1 line_valid width", lv_w, LINE * 4 * t);
    chk(n_p1f == LINE, "R3 reg_clk1 falls", n_p1f, LINE);
    chk(n_comp == 0, "R3 R4 complement errors", n_comp, 0);
    chk(n_p3r == 2 * LINE, "R4 out_clk_a rises", n_p3r, 2 * LINE);
    chk(n_sub == LINE * 2 * t, "R4 sub_sample cycles", n_sub, LINE * 2 * t);
    chk(n_rs == 2 * LINE, "R5 reset pulse cycles", n_rs, 2 * LINE);
    chk(n_rs_long == 0, "R5 reset pulse width", n_rs_long, 0);
    chk(n_shrise == 0, "R7 shutter rise in line", n_shrise, 0);
    for (int c = 0; c < NCOL; c++) begin
      string tg;
      tg = (rels[c] >= EF && rels[c] < EF + EC) || rels[c] >= LINE ?
           $sformatf("R7 shutter%0d rel=%0d", c, rels[c]) :
           $sformatf("R6 shutter%0d rel=%0d", c, rels[c]);
      chk(sh_fall[c] == exp_fall(rels[c], t), tg, sh_fall[c], exp_fall(rels[c], t));
    end
  endtask

  initial begin
    integer base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(xfer_gate == 0, "R9 xfer_gate", xfer_gate, 0);
    chk(reg_clk1 == 1 && lat_clk1 == 1, "R9 reg_clk1/lat_clk1", reg_clk1, 1);
    chk(reg_clk2 == 0 && lat_clk2 == 0, "R9 reg_clk2/lat_clk2", reg_clk2, 0);
    chk(out_clk_a == 0 && out_clk_b == 1, "R9 out_clk_a", out_clk_a, 0);
    chk(sample_reset == 0 && sub_sample == 0, "R9 sample_reset", sample_reset, 0);
    chk(line_valid == 0, "R9 line_valid", line_valid, 0);
    chk(shutter == '1, "R9 shutter", shutter, 7);

    for (int d = 1; d <= 3; d++) begin
      for (int r = 0; r <= 13; r++) begin
        cfg_div = DIV_W'(d);
        cfg_release = {PIX_W'(20), PIX_W'(6), PIX_W'(r)};
        base = lines_done;
        pulse_req();
        wait (lines_done == base + 1);
        @(negedge clk);
        check_line(d + 1, r);
        repeat (5) @(negedge clk);
      end
    end

    // R8 pending requests during readout
    cfg_div = 8'd2;
    cfg_release = {PIX_W'(20), PIX_W'(6), PIX_W'(2)};
    base = lines_done;
    pulse_req();
    wait (line_valid == 1'b1);
    repeat (7) @(negedge clk);
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    repeat (9) @(negedge clk);
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    wait (lines_done == base + 2);
    @(negedge clk);
    chk(end_gap == SETUP * 3, "R8 held request gap", end_gap, SETUP * 3);
    check_line(3, 2);
    repeat (400) @(negedge clk);
    chk(lines_done == base + 2, "R8 only one extra line", lines_done - base, 2);
    chk(line_valid == 0 && xfer_gate == 0, "R8 idle after lines", line_valid, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule